// File: doc/BRIEF.md
# Board Interrupt Aggregator

This block gathers four level-type interrupt requests from peripherals on a board and turns them into a single request line for a host processor. The four sources are a wireless-UART detect (bit 0), a modem ring-indicate (bit 1), a memory-card detect (bit 2) and a 5 V supply-off warning (bit 3). Each request passes through a two-flop synchroniser and is then latched. It stays latched until the host acknowledges it, and the acknowledge succeeds only after the source line has gone idle.

The host reaches the block over a simple strobed register bus that is synchronised into the core clock. The bus is 16 bits wide, and only the low byte carries meaning. A status/acknowledge register reports latched requests as zeros. Writing a one to a bit of that register acknowledges that source. A mask register holds one enable bit per source. The host input that receives the summary line is edge-triggered on a rising edge. For that reason the block briefly drops the line after each successful acknowledge whenever another enabled request is still waiting. The host then sees a fresh edge for the remaining request.

Top module: `brd_irq_agg`

## Requirements
- R1: After reset the mask register reads 0x0000, the status register reads 0x000F (no request latched) and `irq_o` is low.
- R2: A source that stays high long enough to pass the two-flop synchroniser is latched. It stays latched after the source returns low.
- R3: The status register sits at byte offset 0x0C. Bit n (n = 0..3) reads 0 when source n is latched and 1 otherwise. Bits 15..4 always read 0.
- R4: Writing 1 to bit n of offset 0x0C acknowledges source n only if its synchronised input is low. If the input is still high, the request stays latched. Bits written as 0 have no effect.
- R5: The mask register sits at byte offset 0x0E. A write replaces all four enable bits with write-data bits 3..0. A read returns them in bits 3..0, with bits 15..4 at 0.
- R6: A source whose enable bit is 0 keeps its latched status but does not drive `irq_o`.
- R7: `irq_o` is high exactly when at least one latched request is enabled, one clock after that state.
- R8: When an acknowledge removes a latched request, `irq_o` is low for exactly one clock. It then rises again if another enabled request remains latched.
- R9: The initialisation writes (0x00 to offset 0x0E, then 0xFF to offset 0x0C) with idle sources leave every source masked and unlatched.
- R10: Reads of any offset other than 0x0C and 0x0E return 0. Writes to those offsets change no state.
- R11: Each assertion of `bus_strb_i` performs at most one write, however long the strobe is held. A source that drops while the strobe is still held therefore stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 4 | Asynchronous level requests, active high, bit n is source n |
| bus_strb_i | input | 1 | Host access strobe, asynchronous, active high |
| bus_wr_i | input | 1 | 1 for write, 0 for read, stable while strobe is high |
| bus_addr_i | input | 8 | Byte offset, stable while strobe is high |
| bus_wdata_i | input | 16 | Write data, only low byte used |
| bus_rdata_o | output | 16 | Registered read data for the current offset |
| irq_o | output | 1 | Summary request to the host, for a rising-edge input |

## Verification
Sources are pulsed briefly, held across an acknowledge, and dropped while a write strobe is still held. These cases separate a correct level-qualified acknowledge from one that clears blindly or acts again on a long strobe. Pairs of pending sources with one of them acknowledged show whether the output gap is exactly one clock and whether the line re-rises. Mask changes over latched requests show that masking gates only the output and not the status. Accesses to unused offsets and writes to the upper data bits show that only the defined fields hold state.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
  localparam int NSRC   = 4;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h0E;

  typedef struct packed {
    logic            stat_wr;
    logic            mask_wr;
    logic [NSRC-1:0] wbits;
  } bus_cmd_t;
endpackage

// File: rtl/irq_reset_sync.sv
module irq_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_no = stage2_q;
endmodule

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        hold_q <= meta_q;
      end
    end
    assign sync_o[g] = hold_q;
  end
endmodule

// File: rtl/irq_bus_front.sv
module irq_bus_front
  import brd_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   pend_i,
  input  logic [NSRC-1:0]   mask_i,
  output bus_cmd_t          cmd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int STAGES = 3;

  logic [STAGES-1:0] strb_q, strb_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              go;

  always_comb begin
    strb_d = {strb_q[STAGES-2:0], strb_i};
  end

  assign go = strb_q[1] & ~strb_q[2];

  always_comb begin
    cmd_o.stat_wr = go & wr_i & (addr_i == OFF_STAT);
    cmd_o.mask_wr = go & wr_i & (addr_i == OFF_MASK);
    cmd_o.wbits   = wdata_i[NSRC-1:0];
  end

  always_comb begin
    rd_d = '0;
    if (addr_i == OFF_STAT)      rd_d[NSRC-1:0] = ~pend_i;
    else if (addr_i == OFF_MASK) rd_d[NSRC-1:0] = mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= '0;
      rd_q   <= '0;
    end else begin
      strb_q <= strb_d;
      rd_q   <= rd_d;
    end
  end

  assign rdata_o = rd_q;

  p_single_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o.stat_wr || cmd_o.mask_wr) |=> !(cmd_o.stat_wr || cmd_o.mask_wr));
endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import brd_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] lvl_i,
  input  bus_cmd_t        cmd_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] hit_o
);
  logic [NSRC-1:0] pend_q, pend_d, mask_q, mask_d, hit;

  always_comb begin
    hit    = cmd_i.stat_wr ? (cmd_i.wbits & ~lvl_i & pend_q) : '0;
    pend_d = (pend_q & ~hit) | lvl_i;
    mask_d = cmd_i.mask_wr ? cmd_i.wbits : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (cmd_i.mask_wr) mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign hit_o  = hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    p_latch_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_i[g] |=> pend_q[g]);
    p_ack_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i.stat_wr && cmd_i.wbits[g] && !lvl_i[g]) |=> !pend_q[g]);
  end

  p_mask_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.mask_wr && !cmd_i.stat_wr) |=> (pend_q == ($past(pend_q) | $past(lvl_i))));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import brd_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] hit_i,
  output logic            irq_o
);
  logic irq_q, irq_d, act, kick;

  always_comb begin
    act   = |(pend_i & mask_i);
    kick  = |hit_i;
    irq_d = act & ~kick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  p_irq_needs_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(act));
  p_gap_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> !irq_q);
endmodule

// File: rtl/brd_irq_agg.sv
module brd_irq_agg
  import brd_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_strb_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic            rst_n_int;
  logic [NSRC-1:0] lvl, pend, mask, hit;
  bus_cmd_t        cmd;

  irq_reset_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  irq_sync_bank #(.W(NSRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .async_i (src_i),
    .sync_o  (lvl)
  );

  irq_bus_front u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .strb_i  (bus_strb_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .pend_i  (pend),
    .mask_i  (mask),
    .cmd_o   (cmd),
    .rdata_o (bus_rdata_o)
  );

  irq_src_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .lvl_i  (lvl),
    .cmd_i  (cmd),
    .pend_o (pend),
    .mask_o (mask),
    .hit_o  (hit)
  );

  irq_summary u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .pend_i (pend),
    .mask_i (mask),
    .hit_i  (hit),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/tb_brd_irq_agg.sv
module tb_brd_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = '0;
  logic        strb = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;

  brd_irq_agg dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_strb_i(strb),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  logic [3:0] m_pend, m_en, m_rd, m_hit;
  logic       m_irq;
  logic [3:0] src_hist [$];
  bit         strb_hist [$];
  int         rst_age;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_rd = '0; m_irq = 1'b0;
      src_hist = {4'h0, 4'h0}; strb_hist = {1'b0, 1'b0, 1'b0};
      rst_age = 0;
    end else if (rst_age < 2) begin
      rst_age++;
    end else begin
      automatic logic [3:0] seen = src_hist[1];
      automatic bit go = strb_hist[1] && !strb_hist[2];
      m_hit = (go && wr && addr == 8'h0C) ? (wdata[3:0] & ~seen & m_pend) : 4'h0;
      m_rd  = (addr == 8'h0C) ? ~m_pend : (addr == 8'h0E) ? m_en : 4'h0;
      m_irq = ((m_pend & m_en) != 0) && (m_hit == 0);
      m_pend = (m_pend & ~m_hit) | seen;
      if (go && wr && addr == 8'h0E) m_en = wdata[3:0];
      src_hist.push_front(src); void'(src_hist.pop_back());
      strb_hist.push_front(strb); void'(strb_hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && rst_age >= 2) begin
      check(irq == m_irq, "R7 irq vs model", irq, m_irq);
      check(rdata == {12'h0, m_rd}, "R3 rdata vs model", rdata, {12'h0, m_rd});
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; strb = 1'b1;
    repeat (6) @(negedge clk);
    strb = 1'b0;
    repeat (4) @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; wr = 1'b0; strb = 1'b1;
    repeat (3) @(negedge clk);
    check(rdata == exp, tag, rdata, exp);
    strb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_src(input int n, input int len);
    @(negedge clk); src[n] = 1'b1;
    repeat (len) @(negedge clk);
    src[n] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] seqv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    bus_read(8'h0C, 16'h000F, "R1 status after reset");
    bus_read(8'h0E, 16'h0000, "R1 mask after reset");

    // R9 init sequence
    bus_write(8'h0E, 16'h0000);
    bus_write(8'h0C, 16'h00FF);
    bus_read(8'h0C, 16'h000F, "R9 all cleared");
    bus_read(8'h0E, 16'h0000, "R9 all masked");

    // R2 short pulse latches and holds; R6 masked keeps status, no irq
    pulse_src(0, 3);
    bus_read(8'h0C, 16'h000E, "R2 source0 latched");
    check(irq == 1'b0, "R6 masked latched source", irq, 0);

    // R5 mask write, R7 irq follows
    bus_write(8'h0E, 16'hFFF5);
    bus_read(8'h0E, 16'h0005, "R5 mask readback low nibble only");
    check(irq == 1'b1, "R7 enabled pending drives irq", irq, 1);

    // R4 ack blocked while source high
    @(negedge clk); src[2] = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(8'h0C, 16'h0004);
    bus_read(8'h0C, 16'h000A, "R4 ack ignored while active");

    // R11 source drops while strobe is held: no second write
    @(negedge clk); addr = 8'h0C; wdata = 16'h0004; wr = 1'b1; strb = 1'b1;
    repeat (4) @(negedge clk);
    src[2] = 1'b0;
    repeat (10) @(negedge clk);
    strb = 1'b0;
    repeat (3) @(negedge clk);
    wr = 1'b0;
    bus_read(8'h0C, 16'h000A, "R11 held strobe does not repeat");

    // R8 ack of bit0 with bit2 still enabled pending: 1,1,0,1
    @(negedge clk); addr = 8'h0C; wdata = 16'h0001; wr = 1'b1; strb = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); seqv[k] = irq;
    end
    check(seqv == 4'b1011, "R8 one-clock gap then re-rise", seqv, 4'b1011);
    repeat (3) @(negedge clk); strb = 1'b0;
    repeat (3) @(negedge clk); wr = 1'b0;
    bus_read(8'h0C, 16'h000B, "R4 ack of idle source");

    // R4 zero bits ignored
    bus_write(8'h0C, 16'h0000);
    bus_read(8'h0C, 16'h000B, "R4 zero bits ignored");

    // R10 unused offsets
    bus_write(8'h10, 16'h00FF);
    bus_write(8'h0D, 16'h00FF);
    bus_read(8'h10, 16'h0000, "R10 unused offset reads 0");
    bus_read(8'h0D, 16'h0000, "R10 odd offset reads 0");
    bus_read(8'h0E, 16'h0005, "R10 mask untouched");
    bus_read(8'h0C, 16'h000B, "R10 status untouched");

    // R6 mask bit2 off: irq drops, status kept
    bus_write(8'h0E, 16'h0001);
    check(irq == 1'b0, "R6 masked source gates irq", irq, 0);
    bus_read(8'h0C, 16'h000B, "R6 status kept when masked");

    // several sources, then full clear
    pulse_src(1, 4);
    pulse_src(3, 2);
    bus_write(8'h0E, 16'h000F);
    check(irq == 1'b1, "R7 multiple pending", irq, 1);
    bus_write(8'h0C, 16'h00FF);
    bus_read(8'h0C, 16'h000F, "R4 clear all idle");
    check(irq == 1'b0, "R7 nothing pending", irq, 0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule